// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Receive Buffer

This block is the receive half of an asynchronous serial port. It watches a single serial input. It advances only on a sampling strobe that an external baud generator supplies. A low level seen on a strobe while the block is idle is taken as a start bit. The following strobes shift in the data bits, least significant first. When parity is enabled, one parity bit comes next. The frame then closes on the stop-bit strobe. At that point the assembled character goes into a small first-in first-out receive buffer and becomes readable.

The buffer exposes its head entry and its fill count. A fill-level interrupt request follows a software-selected trigger level. Two sticky error flags are provided, and software clears each one with a clear pulse. The parity error flag is set when a character with mismatching parity enters the buffer; that character is still stored. The overrun flag is set when a character completes while the buffer is full; that character is dropped and the stored ones are kept. A second stop bit in the configuration does not delay the end of reception, so a new start bit may follow the first stop bit directly.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset the fill count is 0, the read data is 0, and both error flags and both interrupt requests are low.
- R2: While idle, the block starts a frame only on a strobe that sees the line low. Strobes that see the line high, and line changes between strobes, start nothing.
- R3: With the 8-bit length selected, the eight strobes after the start bit supply data bits 0 to 7 in that order, and the stored character equals those bits.
- R4: With the 7-bit length selected, seven data bits are taken and bit 7 of the read data is 0.
- R5: When parity is enabled, one extra strobe after the last data bit captures the parity bit. The character enters the buffer on the stop-bit strobe, and the fill count rises by one at that clock edge.
- R6: A parity bit is in error when the count of ones over the data bits and the parity bit is odd in even mode (cfg_par_odd=0), or even in odd mode (cfg_par_odd=1). A parity error sets perr_flag, and the character is still stored unchanged.
- R7: perr_flag stays set until a clr_perr pulse, and later good characters do not clear it.
- R8: Reception ends on the first stop-bit strobe even when cfg_stop2=1. A start bit on the very next strobe begins a new frame.
- R9: The buffer holds DEPTH characters and returns them in arrival order on rd_en pulses. A pop with an empty buffer leaves the count at 0.
- R10: irq_full is high exactly when the fill count is at least cfg_trig+1.
- R11: A character that completes while the buffer is full and not being popped sets ovr_flag and irq_ovr and is discarded. The stored entries and the count are unchanged, and clr_ovr clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial input line, idle high |
| samp_en | input | 1 | One-cycle sampling strobe, one per bit time |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | Two stop bits configured (reception still ends at the first) |
| cfg_trig | input | 2 | Fill-level trigger minus one |
| rd_en | input | 1 | Pop the head character |
| clr_perr | input | 1 | Clear the parity error flag |
| clr_ovr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Head character, 0 when empty |
| rx_count | output | 3 | Characters stored |
| perr_flag | output | 1 | Sticky parity error |
| ovr_flag | output | 1 | Sticky overrun |
| irq_full | output | 1 | Fill-level interrupt request |
| irq_ovr | output | 1 | Overrun interrupt request |

## Verification
The assertions assume that the strobe is a single-cycle pulse and that the configuration inputs stay constant while a frame is in progress. They also assume that rd_en and the clear pulses are one cycle wide. The bench changes the configuration only between frames, when the receiver is idle. It spaces strobes several clock cycles apart and drives every input on the falling clock edge, so the frame logic never sees a strobe and a configuration change in the same cycle.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_PAR  = 2'd2,
      ST_STOP = 2'd3
   } frm_state_t;
endpackage

// File: rtl/srx_deframer.sv
module srx_deframer
   import srx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   input  logic              samp_en,
   input  logic              len_full,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              par_bad
);
   localparam int BIT_W = $clog2(DATA_W);

   initial begin
      if (DATA_W < 5) $error("srx_deframer: DATA_W must be at least 5");
   end

   frm_state_t        state_q;
   logic [BIT_W-1:0]  bcnt_q;
   logic [DATA_W-1:0] sr_q;
   logic              acc_q;
   logic              pbit_q;
   logic [BIT_W-1:0]  last_idx;

   assign last_idx = len_full ? BIT_W'(DATA_W - 1) : BIT_W'(DATA_W - 2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bcnt_q  <= '0;
         sr_q    <= '0;
         acc_q   <= 1'b0;
         pbit_q  <= 1'b0;
      end else if (samp_en) begin
         unique case (state_q)
            ST_IDLE: begin
               if (!rxd) begin
                  state_q <= ST_DATA;
                  bcnt_q  <= '0;
                  acc_q   <= 1'b0;
                  pbit_q  <= 1'b0;
               end
            end
            ST_DATA: begin
               sr_q  <= {rxd, sr_q[DATA_W-1:1]};
               acc_q <= acc_q ^ rxd;
               if (bcnt_q == last_idx) state_q <= par_en ? ST_PAR : ST_STOP;
               else                    bcnt_q  <= bcnt_q + 1'b1;
            end
            ST_PAR: begin
               pbit_q  <= rxd;
               state_q <= ST_STOP;
            end
            ST_STOP: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign push      = samp_en && (state_q == ST_STOP);
   assign push_data = len_full ? sr_q : {1'b0, sr_q[DATA_W-1:1]};
   assign par_bad   = push && par_en && ((acc_q ^ pbit_q) != par_odd);

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !samp_en) |=> (state_q == ST_IDLE));
   a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (state_q == ST_IDLE));
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic                       rd,
   output logic [DATA_W-1:0]          rdata,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       drop
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("srx_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  wptr_q, rptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              full, empty, do_wr, do_rd;

   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign empty = (cnt_q == '0);
   assign do_rd = rd && !empty;
   assign do_wr = wr && (!full || do_rd);
   assign drop  = wr && full && !do_rd;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (do_wr && wptr_q == PTR_W'(i)) mem_q[i] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_wr) wptr_q <= wptr_q + 1'b1;
         if (do_rd) rptr_q <= rptr_q + 1'b1;
         if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
         else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign rdata = empty ? '0 : mem_q[rptr_q];
   assign count = cnt_q;

   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
   a_r9_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && rd && !wr) |=> (cnt_q == '0));
   a_r5_push_incr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !rd && !full) |=> (cnt_q == $past(cnt_q) + 1'b1));
   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && full && !rd) |=> ($stable(cnt_q) && $stable(wptr_q)));
endmodule

// File: rtl/srx_status.sv
module srx_status #(
   parameter int CNT_W  = 3,
   parameter int TRIG_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              par_bad,
   input  logic              drop,
   input  logic              clr_perr,
   input  logic              clr_ovr,
   input  logic [CNT_W-1:0]  count,
   input  logic [TRIG_W-1:0] trig,
   output logic              perr_flag,
   output logic              ovr_flag,
   output logic              irq_full,
   output logic              irq_ovr
);
   initial begin
      if (CNT_W <= TRIG_W) $error("srx_status: CNT_W must exceed TRIG_W");
   end

   logic perr_q, ovr_q;
   logic [CNT_W-1:0] level;

   assign level = CNT_W'(trig) + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         perr_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (par_bad)       perr_q <= 1'b1;
         else if (clr_perr) perr_q <= 1'b0;
         if (drop)          ovr_q  <= 1'b1;
         else if (clr_ovr)  ovr_q  <= 1'b0;
      end
   end

   assign perr_flag = perr_q;
   assign ovr_flag  = ovr_q;
   assign irq_full  = (count >= level);
   assign irq_ovr   = ovr_q;

   a_r7_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_q && !clr_perr) |=> perr_q);
   a_r6_perr_set: assert property (@(posedge clk) disable iff (!rst_n)
      par_bad |=> perr_q);
   a_r11_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> ovr_q);
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   parameter int TRIG_W = $clog2(DEPTH),
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   input  logic              samp_en,
   input  logic              cfg_len8,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_stop2,
   input  logic [TRIG_W-1:0] cfg_trig,
   input  logic              rd_en,
   input  logic              clr_perr,
   input  logic              clr_ovr,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  rx_count,
   output logic              perr_flag,
   output logic              ovr_flag,
   output logic              irq_full,
   output logic              irq_ovr
);
   logic              push, par_bad, drop;
   logic [DATA_W-1:0] push_data;
   logic              stop2_unused;

   // A second stop bit never delays the end of reception.
   assign stop2_unused = cfg_stop2;

   srx_deframer #(.DATA_W(DATA_W)) u_deframer (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .samp_en(samp_en),
      .len_full(cfg_len8), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
      .push(push), .push_data(push_data), .par_bad(par_bad)
   );

   srx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr(push), .wdata(push_data), .rd(rd_en),
      .rdata(rd_data), .count(rx_count), .drop(drop)
   );

   srx_status #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_status (
      .clk(clk), .rst_n(rst_n), .par_bad(par_bad), .drop(drop),
      .clr_perr(clr_perr), .clr_ovr(clr_ovr), .count(rx_count),
      .trig(cfg_trig), .perr_flag(perr_flag), .ovr_flag(ovr_flag),
      .irq_full(irq_full), .irq_ovr(irq_ovr)
   );

   a_r10_irq_zero_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == '0) |-> !irq_full);
   a_r4_short_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !cfg_len8) |-> !push_data[DATA_W-1]);
endmodule

// File: tb/serial_rx_fifo_tb.sv
module serial_rx_fifo_tb;
   logic clk = 0, rst_n = 0, rxd = 1, samp_en = 0;
   logic cfg_len8 = 1, cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0;
   logic [1:0] cfg_trig = 0;
   logic rd_en = 0, clr_perr = 0, clr_ovr = 0;
   logic [7:0] rd_data;
   logic [2:0] rx_count;
   logic perr_flag, ovr_flag, irq_full, irq_ovr;
   int tests = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   serial_rx_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .samp_en(samp_en),
      .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_stop2(cfg_stop2), .cfg_trig(cfg_trig), .rd_en(rd_en),
      .clr_perr(clr_perr), .clr_ovr(clr_ovr), .rd_data(rd_data),
      .rx_count(rx_count), .perr_flag(perr_flag), .ovr_flag(ovr_flag),
      .irq_full(irq_full), .irq_ovr(irq_ovr)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic strobe(input logic b);
      @(negedge clk); rxd = b; samp_en = 1;
      @(negedge clk); samp_en = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input bit flip_par);
      int n = cfg_len8 ? 8 : 7;
      logic p = (cfg_len8 ? ^d : ^d[6:0]) ^ cfg_par_odd;
      strobe(1'b0);
      for (int i = 0; i < n; i++) strobe(d[i]);
      if (cfg_par_en) strobe(p ^ flip_par);
      strobe(1'b1);
   endtask

   task automatic pop();
      @(negedge clk); rd_en = 1;
      @(negedge clk); rd_en = 0;
   endtask

   task automatic pulse_clr(input bit which_ovr);
      @(negedge clk); if (which_ovr) clr_ovr = 1; else clr_perr = 1;
      @(negedge clk); clr_ovr = 0; clr_perr = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", rx_count, 0); chk("R1 data", rd_data, 0);
      chk("R1 perr", perr_flag, 0); chk("R1 ovr", ovr_flag, 0);
      chk("R1 irq_full", irq_full, 0); chk("R1 irq_ovr", irq_ovr, 0);

      // R2 high strobes and unstrobed low levels start nothing
      for (int i = 0; i < 12; i++) strobe(1'b1);
      rxd = 0; repeat (6) @(negedge clk); rxd = 1;
      for (int i = 0; i < 12; i++) strobe(1'b1);
      chk("R2 idle count", rx_count, 0);

      // R3/R5/R10 full 8-bit sweep, no parity
      for (int v = 0; v < 256; v++) begin
         send(8'(v), 0);
         chk("R5 count after stop", rx_count, 1);
         chk("R3 data", rd_data, v);
         chk("R10 irq trig0", irq_full, 1);
         pop();
         chk("R9 drained", rx_count, 0);
      end

      // R4/R6 7-bit sweep with even parity, upper bit sent high in value
      cfg_len8 = 0; cfg_par_en = 1; cfg_par_odd = 0;
      for (int v = 0; v < 128; v++) begin
         send(8'(v) | 8'h80, 0);
         chk("R4 data", rd_data, v);
         chk("R6 no perr even", perr_flag, 0);
         pop();
      end

      // R6/R7 odd parity 8-bit
      cfg_len8 = 1; cfg_par_odd = 1;
      for (int v = 0; v < 256; v += 17) begin
         send(8'(v), 0);
         chk("R5 parity data", rd_data, v);
         chk("R6 no perr odd", perr_flag, 0);
         pop();
      end
      send(8'h5A, 1);
      chk("R6 perr set", perr_flag, 1);
      chk("R6 bad char stored", rd_data, 8'h5A);
      pop();
      send(8'h33, 0);
      chk("R7 perr sticky", perr_flag, 1);
      pop();
      pulse_clr(0);
      chk("R7 perr cleared", perr_flag, 0);
      cfg_par_odd = 0;
      send(8'hC1, 1);
      chk("R6 perr even mode", perr_flag, 1);
      pop(); pulse_clr(0);

      // R8 two stop bits configured, next start right after first stop
      cfg_par_en = 0; cfg_stop2 = 1;
      send(8'hA5, 0); send(8'h3C, 0);
      chk("R8 count", rx_count, 2);
      chk("R8 first", rd_data, 8'hA5); pop();
      chk("R8 second", rd_data, 8'h3C); pop();
      cfg_stop2 = 0;

      // R9/R10 fill levels across every trigger
      for (int t = 0; t < 4; t++) begin
         cfg_trig = 2'(t);
         chk("R10 empty irq", irq_full, 0);
         for (int k = 1; k <= 4; k++) begin
            send(8'(16 * t + k), 0);
            chk("R9 fill count", rx_count, k);
            chk("R10 irq level", irq_full, (k >= t + 1) ? 1 : 0);
         end
         for (int k = 1; k <= 4; k++) begin
            chk("R9 order", rd_data, 16 * t + k);
            pop();
         end
         pop();
         chk("R9 pop empty", rx_count, 0);
      end

      // R11 overrun
      cfg_trig = 0;
      for (int k = 0; k < 4; k++) send(8'(8'h90 + k), 0);
      chk("R11 no ovr yet", ovr_flag, 0);
      send(8'hEE, 0);
      chk("R11 ovr flag", ovr_flag, 1);
      chk("R11 irq_ovr", irq_ovr, 1);
      chk("R11 count kept", rx_count, 4);
      for (int k = 0; k < 4; k++) begin
         chk("R11 kept entry", rd_data, 8'h90 + k);
         pop();
      end
      chk("R11 ovr still set", ovr_flag, 1);
      pulse_clr(1);
      chk("R11 ovr cleared", ovr_flag, 0);
      chk("R11 irq_ovr cleared", irq_ovr, 0);

      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            fails++; tests++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule